// File: doc/BRIEF.md
# Edge-to-Message Interrupt Bridge

This block turns a group of device interrupt wires into posted memory writes. Every wire has its own target address, its own data word and its own enable bit, and all three are set through a small register write port. When a wire rises, the bridge sends one write carrying that wire's address and data on a single-beat bus-master port with a valid/ready handshake. A falling edge sends nothing, and neither does a wire that stays high.

Each wire passes through a two-flop synchroniser, and edges are found on the synchronised copy. A detected edge sets a pending flag for its wire. Pending wires are served in rotating order, and the output holds one write at a time. An edge that arrives while the output is stalled is kept until it can be sent. A further edge on a wire that is already pending adds no second write. The address and data are meant to be programmed once during setup. The values sent are the ones held in the table when the write is loaded.

Top module: `edge_msg_bridge`

## Requirements
- R1: After reset, msg_valid is low, every enable bit is clear and no line is pending, so an edge on a line before it is enabled produces no write.
- R2: A cycle with cfg_we high writes the field chosen by cfg_fld for line cfg_idx with cfg_wdata. Field code 0 selects the message address, code 1 the message data, and code 2 the enable bit (cfg_wdata bit 0). A later write uses the new value.
- R3: With the output idle and msg_ready high, msg_valid rises on the fourth rising clock edge, counting the first edge that samples the input line high as the first.
- R4: Each rising edge on an enabled line produces exactly one write. Holding the line high or letting it fall produces none.
- R5: A line whose enable bit is clear ignores its edges and never becomes pending.
- R6: An edge that arrives while the output is busy is held pending and is sent later, so no edge is lost.
- R7: A second edge on a line that is already pending merges with the first, giving one write.
- R8: Pending lines are granted in rotating order. After line k is granted, the search for the next grant starts at line k+1 (wrapping to 0).
- R9: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data do not change. msg_valid only falls after a cycle with msg_ready high.
- R10: An edge that is detected in the same cycle that its line's pending flag is consumed by a load sets the flag again, so a further write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N | Asynchronous device interrupt wires, one per line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Line selected by the configuration write |
| cfg_fld | input | 2 | Field code: 0 address, 1 data, 2 enable |
| cfg_wdata | input | CW | Configuration write value |
| msg_valid | output | 1 | A message write is presented |
| msg_ready | input | 1 | The bus accepts the presented write |
| msg_addr | output | AW | Address of the presented write |
| msg_data | output | DW | Data of the presented write |

## Verification
The critical collision is a new edge being detected on a line in the same cycle that the line's pending flag is cleared because its write is loaded into the output. The bench provokes it by stalling msg_ready while another line's write occupies the output. It then times a second rise on the pending line so that its detected edge meets the release of msg_ready. The result is judged on the number of writes the line produces, which must be two. A behavioural model in the bench also predicts the output in every cycle.

// File: rtl/edge_msg_pkg.sv
package edge_msg_pkg;
  typedef enum logic [1:0] {
    FLD_ADDR = 2'd0,
    FLD_DATA = 2'd1,
    FLD_EN   = 2'd2
  } cfg_fld_e;
endpackage

// File: rtl/msg_edge_sync.sv
module msg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R4: a detected edge lasts exactly one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/msg_cfg_table.sv
module msg_cfg_table
  import edge_msg_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = (AW > DW) ? AW : DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_fld,
  input  logic [CW-1:0] wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [N-1:0]  en
);
  logic [AW-1:0] addr_q [N];
  logic [DW-1:0] data_q [N];
  logic [N-1:0]  en_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic hit;
    assign hit = we && (int'(wr_idx) == i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
        en_q[i]   <= 1'b0;
      end else if (hit) begin
        if (wr_fld == FLD_ADDR) addr_q[i] <= wdata[AW-1:0];
        if (wr_fld == FLD_DATA) data_q[i] <= wdata[DW-1:0];
        if (wr_fld == FLD_EN)   en_q[i]   <= wdata[0];
      end
    end
  end

  assign rd_addr = addr_q[rd_idx];
  assign rd_data = data_q[rd_idx];
  assign en      = en_q;

  // R2: an enable write takes effect on the next cycle
  a_r2_en_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_fld == FLD_EN && int'(wr_idx) < N) |=> en[$past(wr_idx)] == $past(wdata[0]));
endmodule

// File: rtl/msg_rr_arb.sv
module msg_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx,
  output logic [N-1:0]  gnt
);
  logic [IW-1:0] ptr_q;
  logic [IW:0]   pick;

  // first requester at or after the start index, wrapping
  function automatic logic [IW:0] rr_pick(input logic [N-1:0] r, input logic [IW-1:0] p);
    logic [IW:0] res;
    int idx;
    res = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = (int'(p) + k) % N;
      if (r[idx]) res = {1'b1, IW'(idx)};
    end
    return res;
  endfunction

  assign pick    = rr_pick(req, ptr_q);
  assign gnt_vld = pick[IW];
  assign gnt_idx = pick[IW-1:0];
  assign gnt     = gnt_vld ? (N'(1) << gnt_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (take && gnt_vld)
      ptr_q <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + IW'(1);
  end

  // R8: at most one line granted, and only a requesting one
  a_r8_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));
  a_r8_take_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> gnt_vld);
endmodule

// File: rtl/edge_msg_bridge.sv
module edge_msg_bridge #(
  parameter int N      = 4,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int STAGES = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = (AW > DW) ? AW : DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [1:0]    cfg_fld,
  input  logic [CW-1:0] cfg_wdata,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [AW-1:0] msg_addr,
  output logic [DW-1:0] msg_data
);
  logic [N-1:0]  line_rise;
  logic [N-1:0]  line_en;
  logic [N-1:0]  pend_q;
  logic [N-1:0]  pend_set;
  logic [N-1:0]  pend_clr;
  logic [N-1:0]  gnt;
  logic          gnt_vld;
  logic [IW-1:0] gnt_idx;
  logic          out_free;
  logic          load;
  logic [AW-1:0] tab_addr;
  logic [DW-1:0] tab_data;

  for (genvar i = 0; i < N; i++) begin : g_sync
    msg_edge_sync #(.STAGES(STAGES)) i_sync (
      .clk (clk),
      .rst_n (rst_n),
      .din (irq_in[i]),
      .rise (line_rise[i])
    );
  end

  msg_cfg_table #(.N(N), .AW(AW), .DW(DW)) i_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_fld  (cfg_fld),
    .wdata   (cfg_wdata),
    .rd_idx  (gnt_idx),
    .rd_addr (tab_addr),
    .rd_data (tab_data),
    .en      (line_en)
  );

  msg_rr_arb #(.N(N)) i_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (pend_q),
    .take    (load),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx),
    .gnt     (gnt)
  );

  assign out_free = !msg_valid || msg_ready;
  assign load     = gnt_vld && out_free;
  assign pend_set = line_rise & line_en;
  assign pend_clr = load ? gnt : '0;

  // a fresh edge wins over the clear of the same line
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~pend_clr) | pend_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= tab_addr;
      msg_data  <= tab_data;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R9: stalled write is held unchanged
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
  // R9: a write only leaves after it was accepted
  a_r9_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msg_valid) |-> $past(msg_ready));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R5: a disabled idle line stays idle
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[i] && !line_en[i]) |=> !pend_q[i]);
    // R6, R10: an enabled edge is always recorded
    a_r6_r10_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (line_rise[i] && line_en[i]) |=> pend_q[i]);
  end
endmodule

// File: tb/test_edge_msg_bridge.sv
module test_edge_msg_bridge;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IW = 2;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [1:0]    cfg_fld = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          msg_valid;
  logic          msg_ready = 1'b1;
  logic [AW-1:0] msg_addr;
  logic [DW-1:0] msg_data;

  always #4 clk = ~clk;  // 125 MHz

  edge_msg_bridge #(.N(N), .AW(AW), .DW(DW)) i_edge_msg_bridge (
    .clk (clk), .rst_n (rst_n), .irq_in (irq),
    .cfg_we (cfg_we), .cfg_idx (cfg_idx), .cfg_fld (cfg_fld), .cfg_wdata (cfg_wdata),
    .msg_valid (msg_valid), .msg_ready (msg_ready),
    .msg_addr (msg_addr), .msg_data (msg_data)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_s1 [N], m_s2 [N], m_s3 [N];
  bit m_pend [N], m_en [N];
  logic [31:0] m_addr [N], m_data [N];
  bit m_v;
  logic [31:0] m_oa, m_od;
  int m_ptr;

  always @(posedge clk) begin
    int w;
    bit edges [N];
    bit can;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0;
        m_pend[i] = 0; m_en[i] = 0; m_addr[i] = 0; m_data[i] = 0;
      end
      m_v = 0; m_oa = 0; m_od = 0; m_ptr = 0;
    end else begin
      for (int i = 0; i < N; i++) edges[i] = (m_s2[i] == 1) && (m_s3[i] == 0);
      can = !m_v || msg_ready;
      w = -1;
      for (int k = 0; k < N; k++)
        if (w < 0 && m_pend[(m_ptr + k) % N]) w = (m_ptr + k) % N;
      if (m_v && msg_ready) m_v = 0;
      if (can && w >= 0) begin
        m_v = 1; m_oa = m_addr[w]; m_od = m_data[w];
        m_pend[w] = 0; m_ptr = (w + 1) % N;
      end
      for (int i = 0; i < N; i++) if (edges[i] && m_en[i]) m_pend[i] = 1;
      for (int i = 0; i < N; i++) begin
        m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = int'(irq[i]);
      end
      if (cfg_we) begin
        if (cfg_fld == 2'd0) m_addr[cfg_idx] = cfg_wdata;
        if (cfg_fld == 2'd1) m_data[cfg_idx] = cfg_wdata;
        if (cfg_fld == 2'd2) m_en[cfg_idx] = cfg_wdata[0];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(msg_valid == m_v, cur_req, 32'(msg_valid), 32'(m_v));
      if (m_v) begin
        chk(msg_addr == m_oa, cur_req, msg_addr, m_oa);
        chk(msg_data == m_od, cur_req, msg_data, m_od);
      end
    end
  end

  // ---------------- accepted-write monitor ----------------
  int got [N];
  int ord [$];
  logic [31:0] last_data;
  initial for (int i = 0; i < N; i++) got[i] = 0;

  always @(posedge clk) begin
    int ln;
    if (rst_n && msg_valid && msg_ready) begin
      ln = int'((msg_addr - 32'h1000) >> 4);
      if (ln >= 0 && ln < N) begin
        got[ln]++;
        ord.push_back(ln);
      end
      last_data = msg_data;
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cfg(input int idx, input int fld, input logic [31:0] v);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_fld = 2'(fld); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse(input int ln, input int width);
    irq[ln] = 1'b1;
    repeat (width) @(negedge clk);
    irq[ln] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  int exp_cnt [N];

  task automatic chk_counts(input string req);
    for (int i = 0; i < N; i++) chk(got[i] == exp_cnt[i], req, 32'(got[i]), 32'(exp_cnt[i]));
  endtask

  initial begin
    for (int i = 0; i < N; i++) exp_cnt[i] = 0;
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, lines disabled
    cur_req = "R1";
    chk(msg_valid == 1'b0, "R1", 32'(msg_valid), 32'd0);
    pulse(0, 2);
    wait_n(8);
    chk_counts("R1");

    // R2: program every line
    cur_req = "R2";
    for (int i = 0; i < N; i++) begin
      cfg(i, 0, 32'h1000 + 32'(i * 16));
      cfg(i, 1, 32'h100 + 32'(i));
      cfg(i, 2, 32'h1);
    end
    wait_n(2);

    // R3: exact latency
    cur_req = "R3";
    irq[0] = 1'b1;
    wait_n(3);
    chk(msg_valid == 1'b0, "R3", 32'(msg_valid), 32'd0);
    wait_n(1);
    chk(msg_valid == 1'b1, "R3", 32'(msg_valid), 32'd1);
    chk(msg_data == 32'h100, "R3", msg_data, 32'h100);
    wait_n(2);
    irq[0] = 1'b0;
    wait_n(6);
    exp_cnt[0]++;
    chk_counts("R3");

    // R4: held high gives one write, falling gives none
    cur_req = "R4";
    irq[1] = 1'b1;
    wait_n(20);
    exp_cnt[1]++;
    chk_counts("R4");
    irq[1] = 1'b0;
    wait_n(10);
    chk_counts("R4");

    // R6, R7, R9: stall, edge while busy, merged second edge
    cur_req = "R7";
    msg_ready = 1'b0;
    pulse(1, 2);
    wait_n(4);
    chk(msg_valid == 1'b1, "R9", 32'(msg_valid), 32'd1);
    pulse(0, 2);
    pulse(0, 2);
    wait_n(6);
    chk(msg_addr == 32'h1010, "R9", msg_addr, 32'h1010);
    msg_ready = 1'b1;
    wait_n(8);
    exp_cnt[0]++; exp_cnt[1]++;
    chk_counts("R6");
    chk_counts("R7");

    // R8: all lines together while stalled
    cur_req = "R8";
    ord.delete();
    msg_ready = 1'b0;
    irq = '1;
    wait_n(3);
    irq = '0;
    wait_n(8);
    msg_ready = 1'b1;
    wait_n(10);
    for (int i = 0; i < N; i++) exp_cnt[i]++;
    chk_counts("R8");
    chk(ord.size() == N, "R8", 32'(ord.size()), 32'(N));
    if (ord.size() == N)
      for (int k = 1; k < N; k++)
        chk(ord[k] == (ord[k-1] + 1) % N, "R8", 32'(ord[k]), 32'((ord[k-1] + 1) % N));

    // R10: new edge meets the load of its own pending flag
    cur_req = "R10";
    msg_ready = 1'b0;
    pulse(1, 2);
    wait_n(4);
    pulse(0, 2);
    wait_n(3);
    irq[0] = 1'b1;       // first sampled at the next edge
    wait_n(2);           // edge now detected
    msg_ready = 1'b1;    // release coincides with the detected edge
    wait_n(2);
    irq[0] = 1'b0;
    wait_n(10);
    exp_cnt[0] += 2; exp_cnt[1]++;
    chk_counts("R10");

    // R5: disabled line ignores edges
    cur_req = "R5";
    cfg(2, 2, 32'h0);
    pulse(2, 2);
    wait_n(10);
    chk_counts("R5");

    // R2: reprogrammed data is used
    cur_req = "R2";
    cfg(3, 1, 32'hABCD_0003);
    pulse(3, 2);
    wait_n(8);
    exp_cnt[3]++;
    chk_counts("R2");
    chk(last_data == 32'hABCD_0003, "R2", last_data, 32'hABCD_0003);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule